// File: doc/BRIEF.md
# Key-Protected PLL Configuration Register Bank

This block is the register storage that sits in front of a frequency-synthesis PLL. It holds the control word, the integer and fractional feedback divider settings, the reference/post divider word, the calibration control word, and one control word for each of up to sixteen output dividers. Its held values drive the analog macro directly through dedicated output pins. The analog PLL itself is outside the block: two status inputs, one for loop lock and one for calibration lock, are only reflected into read-only status words.

Software can change nothing until a two-word unlock sequence has been written. A wrong key value, or keys written in the wrong order, return the bank to the locked state, and the sequence must be started again. A read-only configuration word, fixed by parameters, reports the PLL flavour and which output dividers exist. Control words of missing dividers behave as if unmapped. The calibration control word drives the macro but reads back as zero, so software cannot confirm what it wrote there.

The bus is a plain register port. A write takes effect on the clock edge where `wr_en` is high. `rdata` is combinational from `addr` and the current register state, so a read completes in the same cycle. There is no handshake and no back-pressure: every access is accepted in one cycle. Only word-aligned byte offsets are decoded.

Top module: `pll_keyed_regbank`

## Requirements
- R1: After reset the bank is locked, `unlocked` is 0, and every writable register, every output pin word and `clkout_en_o` read as zero.
- R2: Writing 0x68EF3490 to offset 0x10 and then 0xD172BC5A to offset 0x14 unlocks the bank. Writes to other offsets between the two key writes do not disturb the sequence. `unlocked` is 1 from the cycle after the second key write.
- R3: A write of any other value to 0x10, a write to 0x14 that is not the second key or does not directly follow an accepted first key, or a new first key while unlocked, locks the bank again. While locked or half-unlocked, writes to every non-key offset are ignored.
- R4: Offset 0x20 is a 32-bit read/write control word, presented on `ctrl_o`.
- R5: Offset 0x30 keeps bits 11:0 as the integer feedback divider (`fb_int_o`). Offset 0x34 keeps bits 23:0 as the fractional divider (`fb_frac_o`). Their other bits read as zero.
- R6: Offset 0x38 keeps all 32 bits of the divider word, with the reference divider in bits 5:0, presented on `div_ctrl_o`.
- R7: A write to offset 0x60 updates `cal_ctrl_o`, but reads of 0x60 always return zero.
- R8: Offset 0x08 is read-only: bits 1:0 carry the PLL type (0 or 1), bit 16+i is set when output divider i exists, and all other bits are zero. Writes to it have no effect.
- R9: Offset 0x24 reads `pll_locked` in bit 0, and offset 0x64 reads `cal_locked` in bit 31. Both are read-only, with other bits zero.
- R10: Output divider i has its 32-bit control word at 0x80 + 4*i, and bit 15 of that word drives `clkout_en_o[i]`. For an absent divider, reads return zero and writes are dropped.
- R11: Unmapped offsets, non-aligned offsets and both key offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pll_locked | input | 1 | Loop lock status from the analog macro |
| cal_locked | input | 1 | Calibration lock status from the analog macro |
| unlocked | output | 1 | High while configuration writes are accepted |
| ctrl_o | output | 32 | Held control word |
| fb_int_o | output | 12 | Integer feedback divider |
| fb_frac_o | output | 24 | Fractional feedback divider |
| div_ctrl_o | output | 32 | Divider word, reference divider in bits 5:0 |
| cal_ctrl_o | output | 32 | Calibration control word as written |
| clkout_en_o | output | 16 | Per-output-divider clock enable (bit 15 of each word) |

## Verification
On every cycle, assertions check the following:
- The bank only opens right after an accepted second key.
- A bad first key always leaves it locked.
- A write while locked leaves every held register unchanged.
- A present divider captures the written word.
- Reads of the calibration word are zero.
- The integer divider word has its upper bits clear.

Only the bench scenarios can show the rest: the whole ordering story across several accesses (second key first, half-open interleaved writes, re-keying while open), the presence mask per divider slot, the fixed configuration word, and the values that reach the output pins. The bench covers these with a reference model that is compared on every cycle.

// File: rtl/pll_rb_pkg.sv
package pll_rb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_KEYA  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_KEYB  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_FBINT = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_FBFRC = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_DIVW  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_CALW  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_CALST = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_ODIV  = 8'h80;

  localparam logic [DATA_W-1:0] KEY_A = 32'h68EF3490;
  localparam logic [DATA_W-1:0] KEY_B = 32'hD172BC5A;

  localparam int ODIV_EN_BIT = 15;

  typedef enum logic [1:0] {
    KEY_SHUT = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/pll_rb_keyguard.sv
module pll_rb_keyguard
  import pll_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en && addr == OFS_KEYA)
      state_d = (wdata == KEY_A) ? KEY_HALF : KEY_SHUT;
    else if (wr_en && addr == OFS_KEYB)
      state_d = (state_q == KEY_HALF && wdata == KEY_B) ? KEY_OPEN : KEY_SHUT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KEY_SHUT;
    else        state_q <= state_d;
  end

  assign open = (state_q == KEY_OPEN);

  // R2: opening only ever follows an accepted second key write
  assert_open_after_keyb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(wr_en && addr == OFS_KEYB && wdata == KEY_B));

  // R3: a bad first key never leaves the bank open
  assert_badkey_relocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_KEYA && wdata != KEY_A) |=> !open);
endmodule

// File: rtl/pll_rb_divbank.sv
module pll_rb_divbank
  import pll_rb_pkg::*;
#(
  parameter int                 NUM_DIV = 16,
  parameter logic [NUM_DIV-1:0] PRESENT = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               hit,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_DIV-1:0] clkout_en
);
  logic [NUM_DIV-1:0] sel;
  logic [DATA_W-1:0]  div_q [NUM_DIV];

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_slot
    assign sel[i] = (addr == ADDR_W'(OFS_ODIV + 4 * i));
    if (PRESENT[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)                div_q[i] <= '0;
        else if (wr_ok && sel[i])  div_q[i] <= wdata;
      end

      // R10: a present divider captures the written word
      assert_div_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel[i]) |=> div_q[i] == $past(wdata));
    end else begin : g_absent
      assign div_q[i] = '0;
    end
    assign clkout_en[i] = div_q[i][ODIV_EN_BIT];
  end

  assign hit = |sel;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_DIV; k++)
      if (sel[k]) rd_data = div_q[k];
  end
endmodule

// File: rtl/pll_keyed_regbank.sv
module pll_keyed_regbank
  import pll_rb_pkg::*;
#(
  parameter int          NUM_DIV     = 16,
  parameter logic [1:0]  PLL_TYPE    = 2'd1,
  parameter logic [15:0] DIV_PRESENT = 16'h0035,
  parameter int          FB_INT_W    = 12,
  parameter int          FB_FRAC_W   = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic                 pll_locked,
  input  logic                 cal_locked,
  output logic                 unlocked,
  output logic [31:0]          ctrl_o,
  output logic [FB_INT_W-1:0]  fb_int_o,
  output logic [FB_FRAC_W-1:0] fb_frac_o,
  output logic [31:0]          div_ctrl_o,
  output logic [31:0]          cal_ctrl_o,
  output logic [NUM_DIV-1:0]   clkout_en_o
);
  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'(PLL_TYPE) | (DATA_W'(DIV_PRESENT[NUM_DIV-1:0]) << 16);

  logic                 wr_ok;
  logic [31:0]          ctrl_q, divw_q, cal_q;
  logic [FB_INT_W-1:0]  fbi_q;
  logic [FB_FRAC_W-1:0] fbf_q;
  logic                 div_hit;
  logic [31:0]          div_rd;

  pll_rb_keyguard u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .open  (unlocked)
  );

  assign wr_ok = wr_en && unlocked;

  pll_rb_divbank #(
    .NUM_DIV (NUM_DIV),
    .PRESENT (DIV_PRESENT[NUM_DIV-1:0])
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .addr      (addr),
    .wdata     (wdata),
    .hit       (div_hit),
    .rd_data   (div_rd),
    .clkout_en (clkout_en_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fbi_q  <= '0;
      fbf_q  <= '0;
      divw_q <= '0;
      cal_q  <= '0;
    end else if (wr_ok) begin
      case (addr)
        OFS_CTRL:  ctrl_q <= wdata;
        OFS_FBINT: fbi_q  <= wdata[FB_INT_W-1:0];
        OFS_FBFRC: fbf_q  <= wdata[FB_FRAC_W-1:0];
        OFS_DIVW:  divw_q <= wdata;
        OFS_CALW:  cal_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_CFG:   rdata = CFG_WORD;
      OFS_CTRL:  rdata = ctrl_q;
      OFS_STAT:  rdata = {31'b0, pll_locked};
      OFS_FBINT: rdata = 32'(fbi_q);
      OFS_FBFRC: rdata = 32'(fbf_q);
      OFS_DIVW:  rdata = divw_q;
      OFS_CALST: rdata = {cal_locked, 31'b0};
      default:   rdata = div_hit ? div_rd : 32'h0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign fb_int_o   = fbi_q;
  assign fb_frac_o  = fbf_q;
  assign div_ctrl_o = divw_q;
  assign cal_ctrl_o = cal_q;

  // R3: a write while not open leaves every held register untouched
  assert_locked_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked) |=> ($stable(ctrl_q) && $stable(fbi_q) && $stable(fbf_q)
                              && $stable(divw_q) && $stable(cal_q) && $stable(clkout_en_o)));

  // R7: calibration word is write-only from the bus view
  assert_cal_noreadback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_CALW) |-> rdata == 32'h0);

  // R5: integer divider word reads with its upper bits clear
  assert_fbint_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_FBINT) |-> rdata[31:FB_INT_W] == '0);
endmodule

// File: tb/sim_pll_keyed_regbank.sv
module sim_pll_keyed_regbank;
  localparam logic [15:0] PRES  = 16'h0035;
  localparam logic [1:0]  PTYPE = 2'd1;
  localparam logic [31:0] KA = 32'h68EF3490;
  localparam logic [31:0] KB = 32'hD172BC5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic pll_locked = 1'b0, cal_locked = 1'b0;
  logic unlocked;
  logic [31:0] ctrl_o, div_ctrl_o, cal_ctrl_o;
  logic [11:0] fb_int_o;
  logic [23:0] fb_frac_o;
  logic [15:0] clkout_en_o;

  always #5 clk = ~clk;

  pll_keyed_regbank #(.NUM_DIV(16), .PLL_TYPE(PTYPE), .DIV_PRESENT(PRES)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pll_locked(pll_locked), .cal_locked(cal_locked),
    .unlocked(unlocked), .ctrl_o(ctrl_o), .fb_int_o(fb_int_o),
    .fb_frac_o(fb_frac_o), .div_ctrl_o(div_ctrl_o), .cal_ctrl_o(cal_ctrl_o),
    .clkout_en_o(clkout_en_o)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference model state
  int key_st;
  logic [31:0] m [256];
  logic [31:0] mcal;

  function automatic bit is_div(logic [7:0] a);
    return (a >= 8'h80 && a <= 8'hBC && a[1:0] == 2'b00);
  endfunction

  function automatic bit div_present(logic [7:0] a);
    int i = int'(a - 8'h80) / 4;
    return PRES[i];
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h08: return {PRES, 14'b0, PTYPE};
      8'h20, 8'h30, 8'h34, 8'h38: return m[a];
      8'h24: return {31'b0, pll_locked};
      8'h64: return {cal_locked, 31'b0};
      default: return (is_div(a) && div_present(a)) ? m[a] : 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] a);
    case (a)
      8'h08: return "R8";
      8'h20: return "R4";
      8'h24, 8'h64: return "R9";
      8'h30, 8'h34: return "R5";
      8'h38: return "R6";
      8'h60: return "R7";
      default: return is_div(a) ? "R10" : "R11";
    endcase
  endfunction

  task automatic mreset();
    for (int i = 0; i < 256; i++) m[i] = 32'h0;
    mcal = 32'h0;
    key_st = 0;
  endtask

  task automatic mwrite(logic [7:0] a, logic [31:0] d);
    if (a == 8'h10) key_st = (d == KA) ? 1 : 0;
    else if (a == 8'h14) key_st = (key_st == 1 && d == KB) ? 2 : 0;
    else if (key_st == 2) begin
      case (a)
        8'h20, 8'h38: m[a] = d;
        8'h30: m[a] = d & 32'h00000FFF;
        8'h34: m[a] = d & 32'h00FFFFFF;
        8'h60: mcal = d;
        default: if (is_div(a) && div_present(a)) m[a] = d;
      endcase
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  task automatic compare_all();
    logic [15:0] en_exp;
    for (int i = 0; i < 16; i++) en_exp[i] = m[8'h80 + 4 * i][15] & PRES[i];
    chk(req_of(addr), rdata, mread(addr));
    chk("R2", {31'b0, unlocked}, {31'b0, key_st == 2});
    chk("R4", ctrl_o, m[8'h20]);
    chk("R5", {20'b0, fb_int_o}, m[8'h30]);
    chk("R5", {8'b0, fb_frac_o}, m[8'h34]);
    chk("R6", div_ctrl_o, m[8'h38]);
    chk("R7", cal_ctrl_o, mcal);
    chk("R10", {16'b0, clkout_en_o}, {16'b0, en_exp});
  endtask

  task automatic step(bit w, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    pll_locked = 1'($urandom);
    cal_locked = 1'($urandom);
    #1;
    compare_all();
    if (w) mwrite(a, d);
  endtask

  task automatic unlock();
    step(1, 8'h10, KA);
    step(1, 8'h14, KB);
  endtask

  logic [7:0] pick [16] = '{8'h08, 8'h10, 8'h14, 8'h20, 8'h24, 8'h30, 8'h34, 8'h38,
                            8'h60, 8'h64, 8'h80, 8'h84, 8'h88, 8'h94, 8'hBC, 8'h3C};

  initial begin
    mreset();
    repeat (3) @(negedge clk);
    // R1: reset state, bank locked and all words clear
    #1;
    compare_all();
    chk("R1", {31'b0, unlocked}, 32'h0);
    rst_n = 1'b1;

    // R3: writes while locked are ignored
    step(1, 8'h20, 32'hFFFF_FFFF);
    step(1, 8'h80, 32'hFFFF_FFFF);
    step(1, 8'h60, 32'h1234_5678);
    step(0, 8'h20, 0);
    step(0, 8'h80, 0);
    // R8: configuration word is fixed, writes do nothing
    step(0, 8'h08, 0);

    // R3: second key first, then first key leaves bank half-open
    step(1, 8'h14, KB);
    step(1, 8'h10, KA);
    step(1, 8'h20, 32'hA5A5_0001);   // ignored while half-open
    step(1, 8'h14, KB);             // R2: opens now
    step(0, 8'h20, 0);

    // R4/R5/R6/R7/R8: open-bank writes
    step(1, 8'h20, 32'h8001_8131);
    step(1, 8'h30, 32'hFFFF_F0A5);
    step(1, 8'h34, 32'hDEAD_BEEF);
    step(1, 8'h38, 32'h0707_0F21);
    step(1, 8'h60, 32'h8012_0000);
    step(0, 8'h60, 0);
    step(1, 8'h08, 32'hFFFF_FFFF);
    step(0, 8'h08, 0);
    step(0, 8'h24, 0);
    step(0, 8'h64, 0);
    step(0, 8'h12, 0);              // R11: unaligned

    // R10: every divider slot, present or absent
    for (int i = 0; i < 16; i++) step(1, 8'(8'h80 + 4 * i), 32'h0000_8000 | i);
    for (int i = 0; i < 16; i++) step(0, 8'(8'h80 + 4 * i), 0);

    // R3: first key while open relocks
    step(1, 8'h10, KA);
    step(1, 8'h20, 32'h0);
    step(1, 8'h14, KB);
    step(0, 8'h20, 0);
    // R3: wrong first key value
    step(1, 8'h10, KA ^ 32'h1);
    step(1, 8'h14, KB);
    step(1, 8'h20, 32'h1);
    // R3: correct first, wrong second
    step(1, 8'h10, KA);
    step(1, 8'h14, KB ^ 32'h8000_0000);
    step(1, 8'h20, 32'h2);
    unlock();
    step(1, 8'h20, 32'h3);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 16);
      logic [7:0] a = ($urandom % 8 == 0) ? 8'($urandom) : pick[r];
      logic [31:0] d = $urandom;
      if (a == 8'h10 && ($urandom % 2 == 0)) d = KA;
      if (a == 8'h14 && ($urandom % 2 == 0)) d = KB;
      if (n % 50 == 0) unlock();
      step(1'($urandom), a, d);
    end

    step(0, 8'h00, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule